// File: doc/BRIEF.md
# Supply-Loss Picture Shutdown Sequencer

This block runs a controlled shutdown of the picture when a monitored supply sags. It compares a digitized supply level against a fixed threshold. On a trigger it forces RGB blanking in the same cycle and sets the vertical overscan to a fixed enlarged value. It waits a fixed number of line periods and then enables tube discharge. From that point it recomputes the overscan from the live supply level, once per vertical period, along one of three linear curves.

When the supply has dropped to a fifth of the level captured at the trigger, the block stops the horizontal drive and freezes the overscan. A sequence that has started always runs to its end. Only a reset returns the block to idle.

All pins are plain control and status signals sampled on every clock. There is no valid/ready stream, so no back-pressure rule applies. `line_tick` and `vtick` are single-cycle strobes. The supply level is treated as a new sample on every cycle.

Top module: `bso_sequencer`

## Requirements
- R1: With `mode` = 00 the block stays idle. `blank_force`, `discharge_en` and `hd_stop` stay low and `ovs` stays at 128, whatever the supply level.
- R2: With `mode` other than 00, a trigger occurs when `supply_lvl` is strictly below `TRIG_LEVEL` (default 200). A level equal to or above the threshold does not trigger.
- R3: `blank_force` goes high combinationally in the same cycle as the trigger condition.
- R4: `ovs` is in units of 1/128. It reads 128 (100%) while idle. It reads 151 (118%) from the cycle after the trigger until discharge starts, and `vtick` does not change it in that window.
- R5: `discharge_en` rises in the cycle after the `LINE_DELAY`-th (default 42) `line_tick` counted after the trigger. It is still low after 41 ticks.
- R6: The supply level and the mode are latched at the trigger as `ref` and slope k. Mode 01 gives k=1, 10 gives k=2 and 11 gives k=4. Changing `mode` later has no effect. During discharge, each `vtick` loads `ovs` = 128 + k*floor(128*(ref-lvl)/ref), with a level drop of zero when lvl >= ref.
- R7: During discharge, when 5*`supply_lvl` <= `ref`, `hd_stop` rises the next cycle. From then on `ovs` holds its last value.
- R8: After a trigger, every output holds its state until reset, even if the supply recovers.
- R9: Asynchronous active-low reset gives `blank_force`=0, `ovs`=128, `discharge_en`=0 and `hd_stop`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00 disabled, 01/10/11 slope k = 1/2/4 |
| supply_lvl | input | LVL_W | Digitized monitored supply |
| line_tick | input | 1 | One-cycle strobe per line period |
| vtick | input | 1 | One-cycle strobe per vertical period |
| blank_force | output | 1 | Force continuous RGB blanking |
| ovs | output | OVS_W | Vertical overscan factor, 128 = 100% |
| discharge_en | output | 1 | Enable tube discharge |
| hd_stop | output | 1 | Stop horizontal drive |

## Verification
The bench builds the block with its defaults: an 8-bit level, a threshold of 200, a 10-bit overscan and the full 42-line delay. The full 42-line window is therefore walked tick by tick, and the check just before the last tick is meaningful. The 8-bit level lets references near the threshold (199) and small drops reach every slope, including the k=4 case that needs the upper overscan bits. The 20% stop condition is hit exactly at its boundary for several references.

// File: rtl/bso_pkg.sv
package bso_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_DISCH = 2'd2,
    ST_DONE  = 2'd3
  } bso_state_e;

  // slope k = 1 << shift
  function automatic logic [1:0] slope_shift(input logic [1:0] m);
    case (m)
      2'b01:   slope_shift = 2'd0;
      2'b10:   slope_shift = 2'd1;
      default: slope_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/bso_line_cnt.sv
module bso_line_cnt #(
  parameter int LINE_DELAY = 42
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CNT_W = $clog2(LINE_DELAY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_DELAY - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run)         cnt_q <= '0;
    else if (tick && !done) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bso_ovs_calc.sv
module bso_ovs_calc #(
  parameter int LVL_W     = 8,
  parameter int OVS_W     = 10,
  parameter int FRAC_BITS = 7
) (
  input  logic [LVL_W-1:0] ref_lvl,
  input  logic [LVL_W-1:0] lvl,
  input  logic [1:0]       shift,
  output logic [OVS_W-1:0] ovs_next,
  output logic             stop_hit
);
  localparam int NUM_W = LVL_W + FRAC_BITS;
  localparam logic [NUM_W-1:0] ONE_N = NUM_W'(1) << FRAC_BITS;

  logic [LVL_W-1:0] drop;
  logic [NUM_W-1:0] num, frac, scaled;
  logic [LVL_W+2:0] lvl_x5;

  always_comb begin
    drop   = (lvl >= ref_lvl) ? '0 : (ref_lvl - lvl);
    num    = {drop, {FRAC_BITS{1'b0}}};
    frac   = (ref_lvl == '0) ? ONE_N : (num / NUM_W'(ref_lvl));
    scaled = frac << shift;
    ovs_next = OVS_W'(ONE_N) + OVS_W'(scaled);
    lvl_x5 = {3'b000, lvl} + {1'b0, lvl, 2'b00};
    stop_hit = lvl_x5 <= {3'b000, ref_lvl};
  end
endmodule

// File: rtl/bso_sequencer.sv
module bso_sequencer
  import bso_pkg::*;
#(
  parameter int LVL_W      = 8,
  parameter int OVS_W      = 10,
  parameter int TRIG_LEVEL = 200,
  parameter int LINE_DELAY = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [LVL_W-1:0] supply_lvl,
  input  logic             line_tick,
  input  logic             vtick,
  output logic             blank_force,
  output logic [OVS_W-1:0] ovs,
  output logic             discharge_en,
  output logic             hd_stop
);
  localparam int FRAC_BITS = 7;
  localparam logic [OVS_W-1:0] OVS_NOM  = OVS_W'(1 << FRAC_BITS);
  localparam logic [OVS_W-1:0] OVS_TRIG = OVS_W'((118 << FRAC_BITS) / 100);
  localparam logic [LVL_W-1:0] TRIG     = LVL_W'(TRIG_LEVEL);

  bso_state_e       state_q;
  logic [LVL_W-1:0] ref_q;
  logic [1:0]       shift_q;
  logic [OVS_W-1:0] ovs_q;
  logic             trig, delay_done, stop_hit;
  logic [OVS_W-1:0] ovs_calc;

  assign trig = (state_q == ST_IDLE) && (mode != 2'b00) && (supply_lvl < TRIG);

  bso_line_cnt #(.LINE_DELAY(LINE_DELAY)) u_lines (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_DELAY),
    .tick  (line_tick),
    .done  (delay_done)
  );

  bso_ovs_calc #(.LVL_W(LVL_W), .OVS_W(OVS_W), .FRAC_BITS(FRAC_BITS)) u_calc (
    .ref_lvl  (ref_q),
    .lvl      (supply_lvl),
    .shift    (shift_q),
    .ovs_next (ovs_calc),
    .stop_hit (stop_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ref_q   <= '0;
      shift_q <= '0;
      ovs_q   <= OVS_NOM;
    end else begin
      case (state_q)
        ST_IDLE: if (trig) begin
          state_q <= ST_DELAY;
          ref_q   <= supply_lvl;
          shift_q <= slope_shift(mode);
          ovs_q   <= OVS_TRIG;
        end
        ST_DELAY: if (delay_done) state_q <= ST_DISCH;
        ST_DISCH: begin
          if (stop_hit)   state_q <= ST_DONE;
          else if (vtick) ovs_q   <= ovs_calc;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign blank_force  = trig || (state_q != ST_IDLE);
  assign ovs          = ovs_q;
  assign discharge_en = (state_q == ST_DISCH) || (state_q == ST_DONE);
  assign hd_stop      = (state_q == ST_DONE);
endmodule

// File: rtl/bso_sequencer_chk.sv
module bso_sequencer_chk #(
  parameter int LVL_W      = 8,
  parameter int OVS_W      = 10,
  parameter int TRIG_LEVEL = 200,
  parameter int LINE_DELAY = 42
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [LVL_W-1:0] supply_lvl,
  input logic             line_tick,
  input logic             vtick,
  input logic             blank_force,
  input logic [OVS_W-1:0] ovs,
  input logic             discharge_en,
  input logic             hd_stop
);
  localparam logic [OVS_W-1:0] OVS_NOM  = OVS_W'(128);
  localparam logic [OVS_W-1:0] OVS_TRIG = OVS_W'((118 * 128) / 100);
  localparam logic [LVL_W-1:0] TRIG     = LVL_W'(TRIG_LEVEL);

  logic        started_q;
  logic [15:0] lines_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      lines_q   <= '0;
    end else begin
      started_q <= blank_force;
      if (started_q && !discharge_en && line_tick && lines_q != 16'hFFFF)
        lines_q <= lines_q + 1'b1;
    end
  end

  assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !blank_force) |=> (ovs == OVS_NOM && !discharge_en && !hd_stop));

  assert_trigger_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && supply_lvl < TRIG) |-> blank_force);

  assert_trip_overscan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_force) |=> (ovs == OVS_TRIG));

  assert_line_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(discharge_en) |-> (lines_q == 16'(LINE_DELAY)));

  assert_stop_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hd_stop |=> (hd_stop && $stable(ovs)));

  assert_blank_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blank_force |=> blank_force);

  assert_discharge_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    discharge_en |-> blank_force);
endmodule

bind bso_sequencer bso_sequencer_chk #(
  .LVL_W(LVL_W), .OVS_W(OVS_W), .TRIG_LEVEL(TRIG_LEVEL), .LINE_DELAY(LINE_DELAY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .supply_lvl(supply_lvl),
  .line_tick(line_tick), .vtick(vtick), .blank_force(blank_force), .ovs(ovs),
  .discharge_en(discharge_en), .hd_stop(hd_stop)
);

// File: tb/bso_sequencer_tb.sv
module bso_sequencer_tb;
  localparam int LVL_W = 8;
  localparam int OVS_W = 10;
  localparam int N_VEC = 6;
  localparam int DLY   = 42;

  localparam logic [1:0] V_MODE [N_VEC] = '{2'b01, 2'b10, 2'b11, 2'b01, 2'b11, 2'b10};
  localparam int         V_REF  [N_VEC] = '{160, 160, 160, 100, 100, 199};
  localparam int         V_LVL  [N_VEC] = '{120, 120, 120,  50,  40, 199};
  localparam int         V_EXP  [N_VEC] = '{160, 192, 256, 192, 432, 128};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [LVL_W-1:0] supply_lvl = 8'd255;
  logic line_tick = 1'b0;
  logic vtick = 1'b0;
  logic blank_force, discharge_en, hd_stop;
  logic [OVS_W-1:0] ovs;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bso_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .supply_lvl(supply_lvl),
    .line_tick(line_tick), .vtick(vtick), .blank_force(blank_force), .ovs(ovs),
    .discharge_en(discharge_en), .hd_stop(hd_stop)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; supply_lvl = 8'd255; line_tick = 1'b0; vtick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_lines(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line_tick = 1'b1;
      @(negedge clk); line_tick = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset values
    do_reset();
    check("R9 blank", int'(blank_force), 0);
    check("R9 ovs", int'(ovs), 128);
    check("R9 disch", int'(discharge_en), 0);
    check("R9 hd", int'(hd_stop), 0);

    // vector table
    for (int v = 0; v < N_VEC; v++) begin
      do_reset();
      mode = V_MODE[v];
      supply_lvl = LVL_W'(V_REF[v]);
      #1 check("R3 blank same cycle", int'(blank_force), 1);
      @(negedge clk);
      check("R4 trip ovs", int'(ovs), 151);
      mode = 2'b00; // R6: mode latched at trigger
      vtick = 1'b1;
      @(negedge clk); vtick = 1'b0;
      check("R4 vtick ignored in delay", int'(ovs), 151);
      run_lines(DLY - 1);
      check("R5 not after 41 lines", int'(discharge_en), 0);
      run_lines(1);
      check("R5 discharge after 42 lines", int'(discharge_en), 1);
      check("R4 held until vtick", int'(ovs), 151);
      @(negedge clk);
      supply_lvl = LVL_W'(V_LVL[v]); vtick = 1'b1;
      @(negedge clk); vtick = 1'b0;
      check("R6 overscan curve", int'(ovs), V_EXP[v]);
      check("R7 no early stop", int'(hd_stop), 0);
      supply_lvl = LVL_W'(V_REF[v] / 5);
      @(negedge clk);
      check("R7 hd_stop at 20%", int'(hd_stop), 1);
      supply_lvl = 8'd255; vtick = 1'b1;
      @(negedge clk); vtick = 1'b0;
      @(negedge clk);
      check("R7 ovs frozen", int'(ovs), V_EXP[v]);
      check("R8 blank sticky", int'(blank_force), 1);
      check("R8 hd sticky", int'(hd_stop), 1);
    end

    // R1: disabled mode ignores a collapsed supply
    do_reset();
    mode = 2'b00; supply_lvl = 8'd10;
    #1 check("R1 no blank", int'(blank_force), 0);
    run_lines(DLY + 2);
    check("R1 ovs nominal", int'(ovs), 128);
    check("R1 no discharge", int'(discharge_en), 0);

    // R2: exactly at threshold does not trigger; one below does
    do_reset();
    mode = 2'b01; supply_lvl = 8'd200;
    #1 check("R2 equal no trigger", int'(blank_force), 0);
    @(negedge clk);
    check("R2 equal ovs nominal", int'(ovs), 128);
    supply_lvl = 8'd199;
    #1 check("R2 below triggers", int'(blank_force), 1);

    // R8: supply recovery during delay does not abort
    @(negedge clk);
    supply_lvl = 8'd255;
    run_lines(DLY);
    check("R8 recovery ignored", int'(discharge_en), 1);
    check("R8 blank held", int'(blank_force), 1);

    // R9: reset mid-sequence
    do_reset();
    check("R9 reset mid-run blank", int'(blank_force), 0);
    check("R9 reset mid-run ovs", int'(ovs), 128);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule